// File: doc/BRIEF.md
# Address Lock Manager with Eight-Slot Tag Table

This block guards a shared word memory with per-address locks. A small associative table holds up to eight locked word addresses. Every command arrives on one command port and carries a requester-class bit. A blocking-class requester that asks for a lock already held is parked in a single waiting slot until a release lets it through. A non-blocking-class requester is never parked: it gets its data back together with a failure flag.

Locks are taken by a locking read and dropped either by a bare release or by a combined write-then-release. Plain reads and writes go straight to the memory and take no notice of the table. After any release, the parked request is tried again in the very next cycle. In that cycle the command port is held off so the retry can use the table and the memory alone. The memory is a simple behavioural array with a registered read port.

Top module: `addr_lock_unit`

## Requirements
- R1: A locking read (op code 2) of an address that is not held, issued while a table slot is free, returns the stored word with `rsp_lock_fail`=0 and leaves that address held. No address is ever held twice.
- R2: Write-and-release (op code 3) stores exactly one word at the address and drops its lock in the same command.
- R3: Release (op code 4) drops the lock on the address and leaves the stored data unchanged.
- R4: A non-blocking (`cmd_blocking`=0) locking read of a held address responds with `rsp_lock_fail`=1 and the current stored word, and leaves the lock state unchanged.
- R5: A blocking (`cmd_blocking`=1) locking read of a held address produces no response until a release of that address. While it waits, `cmd_ready` is low whenever `cmd_blocking` is 1, and non-blocking commands are still accepted. When it is granted, the address is held for it.
- R6: At most eight addresses are held at once. With all eight slots in use, a locking read of any other address is treated as a failed lock: it is flagged for a non-blocking requester and parked for a blocking one.
- R7: A release or write-and-release of an address that is not held changes no lock, sets the sticky `spurious_unlock` output, and the write part of write-and-release still takes place.
- R8: Plain read (op code 0) and plain write (op code 1) access the memory whatever the lock state is.
- R9: After reset, `cmd_ready`=1, `rsp_valid`=0, `spurious_unlock`=0 and no address is held.
- R10: Every accepted command other than a parked locking read raises `rsp_valid` for one cycle, in the cycle after it is accepted. Op codes 5 to 7 are acknowledged and have no effect.
- R11: In the cycle after a release while a request is parked, the parked request is re-evaluated and `cmd_ready` is low. If it is granted, its response follows one cycle later. If it is still blocked, it stays parked with no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high |
| cmd_op | input | 3 | 0 read, 1 write, 2 locking read, 3 write-and-release, 4 release |
| cmd_blocking | input | 1 | 1 = blocking requester class, 0 = flag-reporting class |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_lock_fail | output | 1 | Locking read did not obtain the lock |
| rsp_rdata | output | DATA_W | Read data for read-type commands |
| spurious_unlock | output | 1 | Sticky: a release hit an address that was not held |

## Verification
The locking function is exercised with three kinds of pattern. A free address with free slots shows that a grant takes the lock. A held address from each requester class separates the flag-and-data path from the parking path. A completely filled table with a new address separates the capacity limit from address contention. Releases of the parked address and of an unrelated held address show whether the re-evaluation after a release grants only when the wanted address has actually become free. Plain accesses to held addresses and releases of addresses that are not held show that locks are ignored where they should be and that spurious releases leave the table untouched.

// File: rtl/lock_pkg.sv
package lock_pkg;

    typedef enum logic [2:0] {
        OP_READ     = 3'd0,
        OP_WRITE    = 3'd1,
        OP_RDLOCK   = 3'd2,
        OP_WRUNLOCK = 3'd3,
        OP_UNLOCK   = 3'd4
    } lock_op_e;

    // Per-cycle action vector produced by the decision function.
    typedef struct packed {
        logic rd;     // read memory
        logic wr;     // write memory
        logic grab;   // allocate table slot
        logic drop;   // free matching table slot
        logic fail;   // report failed lock
        logic park;   // store request in waiting slot
        logic unpark; // waiting request granted
        logic spur;   // release of an address not held
        logic ack;    // emit response next cycle
    } lock_act_t;

    function automatic lock_act_t decide(input logic go, input logic [2:0] op,
                                         input logic blocking, input logic retry,
                                         input logic hit, input logic full);
        lock_act_t a;
        a = '0;
        if (go) begin
            case (lock_op_e'(op))
                OP_READ: begin
                    a.rd  = 1'b1;
                    a.ack = 1'b1;
                end
                OP_WRITE: begin
                    a.wr  = 1'b1;
                    a.ack = 1'b1;
                end
                OP_RDLOCK: begin
                    if (!hit && !full) begin
                        a.grab   = 1'b1;
                        a.rd     = 1'b1;
                        a.ack    = 1'b1;
                        a.unpark = retry;
                    end else if (blocking) begin
                        a.park = !retry;
                    end else begin
                        a.rd   = 1'b1;
                        a.ack  = 1'b1;
                        a.fail = 1'b1;
                    end
                end
                OP_WRUNLOCK: begin
                    a.wr   = 1'b1;
                    a.ack  = 1'b1;
                    a.drop = hit;
                    a.spur = !hit;
                end
                OP_UNLOCK: begin
                    a.ack  = 1'b1;
                    a.drop = hit;
                    a.spur = !hit;
                end
                default: a.ack = 1'b1;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/lock_cam.sv
module lock_cam #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 10,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  look_addr,
    input  logic               grab,
    input  logic               drop,
    output logic [ENTRIES-1:0] match_vec,
    output logic               hit,
    output logic               full
);

    logic [ENTRIES-1:0] ent_vld;
    logic [ADDR_W-1:0]  ent_tag [ENTRIES];
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   free_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = ent_vld[g] && (ent_tag[g] == look_addr);
    end

    assign hit  = |match_vec;
    assign full = &ent_vld;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    // lowest free slot wins
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_vld[i]) free_idx = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_vld <= '0;
        end else begin
            if (grab && !full && !hit) begin
                ent_vld[free_idx] <= 1'b1;
                ent_tag[free_idx] <= look_addr;
            end
            if (drop && hit) begin
                ent_vld[hit_idx] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lock_pend.sv
module lock_pend #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              park,
    input  logic              unpark,
    input  logic [ADDR_W-1:0] park_addr,
    input  logic              drop_ev,
    output logic              pend_valid,
    output logic [ADDR_W-1:0] pend_addr,
    output logic              retry_now
);

    logic rel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            rel_q      <= 1'b0;
        end else begin
            rel_q <= drop_ev;
            if (park) begin
                pend_valid <= 1'b1;
                pend_addr  <= park_addr;
            end else if (unpark) begin
                pend_valid <= 1'b0;
            end
        end
    end

    assign retry_now = pend_valid && rel_q;

endmodule

// File: rtl/lock_word_mem.sv
module lock_word_mem #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr) cells[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= cells[addr];
    end

endmodule

// File: rtl/addr_lock_unit.sv
module addr_lock_unit import lock_pkg::*; #(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_blocking,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic              rsp_lock_fail,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              spurious_unlock
);

    logic               retry_now;
    logic               pend_valid;
    logic [ADDR_W-1:0]  pend_addr;
    logic               go;
    logic [2:0]         cur_op;
    logic               cur_blk;
    logic [ADDR_W-1:0]  cur_addr;
    logic [ENTRIES-1:0] match_vec;
    logic               hit;
    logic               full;
    logic               drop_ev;
    lock_act_t          act;

    // the retry owns the cycle; a blocking requester stalls while one waits
    assign cmd_ready = !retry_now && !(pend_valid && cmd_blocking);
    assign go        = retry_now || (cmd_valid && cmd_ready);

    always_comb begin
        if (retry_now) begin
            cur_op   = OP_RDLOCK;
            cur_blk  = 1'b1;
            cur_addr = pend_addr;
        end else begin
            cur_op   = cmd_op;
            cur_blk  = cmd_blocking;
            cur_addr = cmd_addr;
        end
    end

    assign act     = decide(go, cur_op, cur_blk, retry_now, hit, full);
    assign drop_ev = act.drop;

    lock_cam #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_cam (
        .clk       (clk),
        .rst       (rst),
        .look_addr (cur_addr),
        .grab      (act.grab),
        .drop      (act.drop),
        .match_vec (match_vec),
        .hit       (hit),
        .full      (full)
    );

    lock_pend #(.ADDR_W(ADDR_W)) u_pend (
        .clk        (clk),
        .rst        (rst),
        .park       (act.park),
        .unpark     (act.unpark),
        .park_addr  (cur_addr),
        .drop_ev    (drop_ev),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr),
        .retry_now  (retry_now)
    );

    lock_word_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .rd    (act.rd),
        .wr    (act.wr),
        .addr  (cur_addr),
        .wdata (cmd_wdata),
        .rdata (rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid       <= 1'b0;
            rsp_lock_fail   <= 1'b0;
            spurious_unlock <= 1'b0;
        end else begin
            rsp_valid     <= act.ack;
            rsp_lock_fail <= act.fail;
            if (act.spur) spurious_unlock <= 1'b1;
        end
    end

endmodule

// File: rtl/lock_unit_chk.sv
module lock_unit_chk #(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic [2:0]         cmd_op,
    input logic               cmd_blocking,
    input logic               rsp_valid,
    input logic               rsp_lock_fail,
    input logic               spurious_unlock,
    input logic [ENTRIES-1:0] match_vec,
    input logic               pend_valid,
    input logic               drop_ev
);

    // R1: an address occupies at most one slot
    assert_single_match_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

    // R4: a fail flag only travels with a response
    assert_fail_has_rsp_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_lock_fail |-> rsp_valid);

    // R5: blocking class is held off while a request waits
    assert_blk_stall_R5: assert property (@(posedge clk) disable iff (rst)
        (pend_valid && cmd_blocking) |-> !cmd_ready);

    // R7: spurious flag is sticky
    assert_spur_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        spurious_unlock |=> spurious_unlock);

    // R9: reset clears response and status
    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !spurious_unlock));

    // R10: non-locking commands answer one cycle after acceptance
    assert_ack_next_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_op != 3'd2) |=> rsp_valid);

    // R11: the cycle after a release with a waiter belongs to the retry
    assert_retry_slot_R11: assert property (@(posedge clk) disable iff (rst)
        (pend_valid && drop_ev) |=> !cmd_ready);

endmodule

bind addr_lock_unit lock_unit_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cmd_valid       (cmd_valid),
    .cmd_ready       (cmd_ready),
    .cmd_op          (cmd_op),
    .cmd_blocking    (cmd_blocking),
    .rsp_valid       (rsp_valid),
    .rsp_lock_fail   (rsp_lock_fail),
    .spurious_unlock (spurious_unlock),
    .match_vec       (match_vec),
    .pend_valid      (pend_valid),
    .drop_ev         (drop_ev)
);

// File: tb/tb_addr_lock_unit.sv
`timescale 1ns/1ps
module tb_addr_lock_unit;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam logic [2:0] RD = 3'd0, WR = 3'd1, RL = 3'd2, WU = 3'd3, UL = 3'd4;

    logic              clk = 1'b0;
    logic              rst;
    logic              cmd_valid;
    logic              cmd_ready;
    logic [2:0]        cmd_op;
    logic              cmd_blocking;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata;
    logic              rsp_valid;
    logic              rsp_lock_fail;
    logic [DATA_W-1:0] rsp_rdata;
    logic              spurious_unlock;

    always #4 clk = ~clk;

    addr_lock_unit #(.ENTRIES(8), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_blocking(cmd_blocking), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_lock_fail(rsp_lock_fail),
        .rsp_rdata(rsp_rdata), .spurious_unlock(spurious_unlock)
    );

    typedef struct {
        logic        chk_data;
        logic [31:0] data;
        logic        fail;
        string       tag;
    } exp_t;

    exp_t        sb [$];
    logic [31:0] model [1024];
    int          nchk = 0;
    int          nfail = 0;
    bit          done = 1'b0;

    function automatic logic [ADDR_W-1:0] ad(input int i);
        return ADDR_W'(16 + 3 * i);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done && rsp_valid) begin
            exp_t e;
            nchk++;
            if (sb.size() == 0) begin
                nfail++;
                $display("FAIL unexpected response actual=%0h expected=none", rsp_rdata);
            end else begin
                e = sb.pop_front();
                if (rsp_lock_fail !== e.fail || (e.chk_data && rsp_rdata !== e.data)) begin
                    nfail++;
                    $display("FAIL %s actual=%0h/%0b expected=%0h/%0b",
                             e.tag, rsp_rdata, rsp_lock_fail, e.data, e.fail);
                end
            end
        end
    end

    task automatic expect_rsp(input logic chk, input logic [31:0] d, input logic f, input string tag);
        exp_t e;
        e.chk_data = chk; e.data = d; e.fail = f; e.tag = tag;
        sb.push_back(e);
    endtask

    // call at a falling edge; returns at the falling edge after acceptance
    task automatic send(input logic [2:0] op, input logic blk, input logic [ADDR_W-1:0] a,
                        input logic [31:0] wd);
        cmd_op = op; cmd_blocking = blk; cmd_addr = a; cmd_wdata = wd; cmd_valid = 1'b1;
        #1;
        while (!cmd_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic nb_read(input int i, input string tag);
        expect_rsp(1'b1, model[ad(i)], 1'b0, tag);
        send(RD, 1'b0, ad(i), '0);
    endtask

    task automatic nb_write(input int i, input logic [31:0] d, input string tag);
        expect_rsp(1'b0, '0, 1'b0, tag);
        send(WR, 1'b0, ad(i), d);
        model[ad(i)] = d;
    endtask

    task automatic nb_lock(input int i, input logic f, input string tag);
        expect_rsp(1'b1, model[ad(i)], f, tag);
        send(RL, 1'b0, ad(i), '0);
    endtask

    task automatic nb_unlock(input int i, input string tag);
        expect_rsp(1'b0, '0, 1'b0, tag);
        send(UL, 1'b0, ad(i), '0);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_blocking = 1'b0;
        cmd_addr = '0; cmd_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        check(cmd_ready === 1'b1, "R9 ready", 32'(cmd_ready), 1);
        check(rsp_valid === 1'b0, "R9 rsp_valid", 32'(rsp_valid), 0);
        check(spurious_unlock === 1'b0, "R9 spurious", 32'(spurious_unlock), 0);
        @(negedge clk);

        for (int i = 0; i < 10; i++) nb_write(i, 32'hA500_0000 + 32'(i), "R8 init write");

        // R10 latency: response the cycle after acceptance
        expect_rsp(1'b1, model[ad(9)], 1'b0, "R10 read data");
        send(RD, 1'b0, ad(9), '0);
        check(rsp_valid === 1'b1, "R10 latency", 32'(rsp_valid), 1);
        expect_rsp(1'b0, '0, 1'b0, "R10 undefined op ack");
        send(3'd6, 1'b0, ad(9), 32'hDEAD_BEEF);
        check(rsp_valid === 1'b1, "R10 undefined op latency", 32'(rsp_valid), 1);
        nb_read(9, "R10 undefined op no effect");

        // R1 grant, R4 flag on held address
        nb_lock(0, 1'b0, "R1 lock grant");
        nb_lock(0, 1'b1, "R4 lock fail with data");
        // R8 plain access ignores lock
        nb_write(0, 32'h1111_2222, "R8 write held");
        nb_read(0, "R8 read held");

        // R2 write-and-release
        expect_rsp(1'b0, '0, 1'b0, "R2 ack");
        send(WU, 1'b0, ad(0), 32'hE0E0_0000);
        model[ad(0)] = 32'hE0E0_0000;
        nb_read(0, "R2 data written");
        nb_lock(0, 1'b0, "R2 lock released");

        // R3 release keeps data
        nb_unlock(0, "R3 ack");
        nb_read(0, "R3 data kept");
        nb_lock(0, 1'b0, "R3 lock released");
        nb_unlock(0, "R3 cleanup");
        check(spurious_unlock === 1'b0, "R7 no spurious yet", 32'(spurious_unlock), 0);

        // R7 spurious releases
        nb_unlock(5, "R7 ack");
        #1;
        check(spurious_unlock === 1'b1, "R7 spurious set", 32'(spurious_unlock), 1);
        expect_rsp(1'b0, '0, 1'b0, "R7 wu ack");
        send(WU, 1'b0, ad(6), 32'h6666_0006);
        model[ad(6)] = 32'h6666_0006;
        nb_read(6, "R7 wu wrote");
        nb_lock(5, 1'b0, "R7 no lock change");
        nb_lock(5, 1'b1, "R7 relock held");
        nb_unlock(5, "R7 cleanup");

        // R5 / R11 blocking wait
        nb_lock(1, 1'b0, "R5 setup A1");
        nb_lock(2, 1'b0, "R5 setup A2");
        send(RL, 1'b1, ad(1), '0);   // parks, no response expected
        idle_cycles(3);
        cmd_blocking = 1'b1;
        #1;
        check(cmd_ready === 1'b0, "R5 blocking stalled", 32'(cmd_ready), 0);
        nb_read(3, "R5 non-blocking still served");
        nb_unlock(2, "R11 unrelated release");
        #1;
        check(cmd_ready === 1'b0, "R11 retry cycle", 32'(cmd_ready), 0);
        idle_cycles(3);               // still blocked: monitor flags any response
        expect_rsp(1'b0, '0, 1'b0, "R11 release ack");
        expect_rsp(1'b1, model[ad(1)], 1'b0, "R5 granted after release");
        send(UL, 1'b0, ad(1), '0);
        #1;
        check(cmd_ready === 1'b0, "R11 retry cycle grant", 32'(cmd_ready), 0);
        idle_cycles(2);
        check(sb.size() == 0, "R5 grant delivered", 32'(sb.size()), 0);
        nb_lock(1, 1'b1, "R5 granted holds lock");
        nb_unlock(1, "R5 cleanup");

        // R6 capacity
        for (int i = 0; i < 8; i++) nb_lock(i, 1'b0, "R6 fill");
        nb_lock(8, 1'b1, "R6 full fails");
        send(RL, 1'b1, ad(8), '0);   // parks on full table
        idle_cycles(2);
        expect_rsp(1'b0, '0, 1'b0, "R6 release ack");
        expect_rsp(1'b1, model[ad(8)], 1'b0, "R6 blocked grant on slot free");
        send(UL, 1'b0, ad(3), '0);
        idle_cycles(3);
        check(sb.size() == 0, "R6 grant delivered", 32'(sb.size()), 0);
        nb_lock(8, 1'b1, "R6 new holder");
        nb_lock(9, 1'b1, "R6 full again");

        idle_cycles(3);
        check(sb.size() == 0, "R10 all responses seen", 32'(sb.size()), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule